// File: doc/BRIEF.md
# Buffer checksum generator

This block produces a 16-bit CRC over the bytes that sit in a command/response data buffer, so that a host can confirm that a transfer arrived intact. A register front end pulses `start_i` together with the live buffer pointer on `len_i`. The block then walks the buffer through a synchronous read port, one byte address per clock, from index zero up to the pointer, and folds each returned byte into the CRC.

The polynomial is x^16 + x^12 + x^5 + 1 (0x1021). The CRC register starts at zero, each byte enters most significant bit first, and no final inversion is applied. The finished value is presented on `crc_o` with its two bytes exchanged, and `done_o` pulses for one cycle as it appears. The result stays on `crc_o` until the next completion. A zero length completes at once with a zero result. A fresh start pulse abandons any run in progress and begins again from the zero seed.

The buffer storage, the register bus and any policy on when a checksum may be requested are outside this block.

Top module: `crc_buf_sum`

## Requirements
- R1: The CRC uses polynomial 0x1021 and seed 0x0000, feeds each byte MSB first and applies no final XOR. The ASCII bytes "123456789" give the raw value 0x31C3.
- R2: `crc_o[15:8]` carries the low byte of the raw CRC and `crc_o[7:0]` its high byte. The "123456789" case therefore reads 0xC331.
- R3: Take the edge at which `start_i` is sampled high as edge 0. For an effective length L > 0, `rd_en_o` is high in the cycles after edges 0 through L-1, and after edge k it presents `rd_addr_o` = k. At all other times it is low.
- R4: The read port has one cycle of latency. The byte on `rd_data_i` in the cycle after a cycle with `rd_en_o` high is the buffer byte at the address presented, and it is folded into the CRC.
- R5: For L > 0, `done_o` is high only in the cycle after edge L+1, and `crc_o` carries the new result in that same cycle.
- R6: For `len_i` = 0, no read is issued. `done_o` is high and `crc_o` is 0x0000 in the cycle after edge 0.
- R7: A start pulse during a run restarts from the zero seed. Reads already in flight are discarded, and the abandoned run produces no `done_o`.
- R8: A `len_i` greater than the buffer depth 2^ADDR_W is treated as the depth.
- R9: After reset `crc_o` = 0, `done_o` = 0 and `rd_en_o` = 0. `crc_o` changes only in a cycle where `done_o` is high.
- R10: `done_o` is a single-cycle pulse for each completed run, unless a zero-length start follows straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or restart) a checksum run |
| len_i | input | ADDR_W+1 | Number of buffer bytes to cover, sampled with `start_i` |
| rd_en_o | output | 1 | Buffer read strobe |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after `rd_en_o` |
| crc_o | output | 16 | Byte-swapped CRC result, held between runs |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a restart that lands while the old run still has a byte in the read pipeline. The worst version lands on the very edge at which the old run would absorb its last byte and complete. The stimulus issues second start pulses at chosen offsets into a run, including exactly L+1 edges after the first start. It also issues zero-length restarts in the middle of a run and random restart points. The cycle-accurate model expects no completion from the abandoned run, and it expects a result computed only over the new run's bytes.

// File: rtl/crc_buf_pkg.sv
package crc_buf_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h0000;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // presentation order: low byte of the raw CRC goes to the upper lane
  function automatic crc_t swap_lanes(crc_t v);
    return {v[BYTE_W-1:0], v[CRC_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_buf_pkg::*;
#(
  parameter crc_t POLY = CRC_POLY
) (
  input  crc_t  crc_i,
  input  byte_t data_i,
  output crc_t  crc_o
);
  crc_t chain [0:BYTE_W];

  assign chain[0] = crc_i;

  // one shift-and-reduce stage per data bit, MSB first
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[BYTE_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[BYTE_W];
endmodule

// File: rtl/crc_rd_seq.sv
module crc_rd_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_last_o,
  output logic              len_zero_o
);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] DEPTH_L = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] left_q;
  logic             issuing_q;

  assign eff_len    = (len_i > DEPTH_L) ? DEPTH_L : len_i;
  assign len_zero_o = (len_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      rd_last_o <= 1'b0;
      left_q    <= '0;
      issuing_q <= 1'b0;
    end else if (start_i) begin
      rd_addr_o <= '0;
      if (len_zero_o) begin
        rd_en_o   <= 1'b0;
        rd_last_o <= 1'b0;
        issuing_q <= 1'b0;
      end else begin
        rd_en_o   <= 1'b1;
        rd_last_o <= (eff_len == ONE_L);
        left_q    <= eff_len - ONE_L;
        issuing_q <= (eff_len != ONE_L);
      end
    end else if (issuing_q) begin
      rd_en_o   <= 1'b1;
      rd_addr_o <= rd_addr_o + 1'b1;
      rd_last_o <= (left_q == ONE_L);
      left_q    <= left_q - ONE_L;
      issuing_q <= (left_q != ONE_L);
    end else begin
      rd_en_o   <= 1'b0;
      rd_last_o <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import crc_buf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  input  logic  len_zero_i,
  input  logic  rd_en_i,
  input  logic  rd_last_i,
  input  byte_t rd_data_i,
  output crc_t  crc_o,
  output logic  done_o
);
  logic dv_q, dv_last_q;
  crc_t acc_q, acc_nxt;

  crc_byte_step #(.POLY(CRC_POLY)) u_step (
    .crc_i  (acc_q),
    .data_i (rd_data_i),
    .crc_o  (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q      <= 1'b0;
      dv_last_q <= 1'b0;
      acc_q     <= CRC_SEED;
      crc_o     <= '0;
      done_o    <= 1'b0;
    end else if (start_i) begin
      // drop whatever the old run still has in the read pipeline
      dv_q      <= 1'b0;
      dv_last_q <= 1'b0;
      acc_q     <= CRC_SEED;
      done_o    <= len_zero_i;
      if (len_zero_i) crc_o <= swap_lanes(CRC_SEED);
    end else begin
      dv_q      <= rd_en_i;
      dv_last_q <= rd_last_i;
      done_o    <= 1'b0;
      if (dv_q) acc_q <= acc_nxt;
      if (dv_q && dv_last_q) begin
        crc_o  <= swap_lanes(acc_nxt);
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc_buf_sum.sv
module crc_buf_sum #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic [15:0]       crc_o,
  output logic              done_o
);
  logic rd_last, len_zero;

  crc_rd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_i      (len_i),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .rd_last_o  (rd_last),
    .len_zero_o (len_zero)
  );

  crc_acc u_acc (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_zero_i (len_zero),
    .rd_en_i    (rd_en_o),
    .rd_last_i  (rd_last),
    .rd_data_i  (rd_data_i),
    .crc_o      (crc_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/crc_buf_sum_chk.sv
module crc_buf_sum_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W:0]   len_i,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [15:0]       crc_o,
  input logic              done_o
);
  p_first_read_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i != '0) |=> (rd_en_o && rd_addr_o == '0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en_o) && rd_en_o && !$past(start_i))
      |-> (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1)));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i == '0) |=> (done_o && crc_o == 16'h0000 && !rd_en_o));

  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i != '0) |=> !done_o);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_o) |-> done_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !done_o);
endmodule

bind crc_buf_sum crc_buf_sum_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .len_i     (len_i),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .crc_o     (crc_o),
  .done_o    (done_o)
);

// File: tb/crc_buf_sum_tb.sv
module crc_buf_sum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LEN_W  = ADDR_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  len_i = '0;
  logic              rd_en_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [7:0]        rd_data_i = '0;
  logic [15:0]       crc_o;
  logic              done_o;

  crc_buf_sum #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .crc_o(crc_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // buffer stand-in with a one-cycle synchronous read
  logic [7:0] mem [DEPTH];
  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  int checks = 0, fails = 0, done_seen = 0;
  bit cmp_on = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ mem[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  function automatic int swp(logic [15:0] v);
    return int'({v[7:0], v[15:8]});
  endfunction

  // reference model, advanced once per clock edge
  bit          m_active = 0;
  int          m_s = 0, m_L = 0;
  logic [15:0] m_val = '0;
  bit          e_rd_en = 0, e_done = 0;
  int          e_addr = 0, e_crc = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; e_rd_en = 0; e_done = 0; e_crc = 0; e_addr = 0;
    end else begin
      if (start_i) begin
        m_active = 1; m_s = 0;
        m_L = (int'(len_i) > DEPTH) ? DEPTH : int'(len_i);
        m_val = ref_crc(m_L);
      end else if (m_active) m_s++;
      e_rd_en = m_active && (m_s < m_L);
      e_addr  = m_s;
      e_done  = m_active && ((m_L == 0) ? (m_s == 0) : (m_s == m_L + 1));
      if (e_done) begin
        e_crc = swp(m_val);
        m_active = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R3", "rd_en_o", int'(rd_en_o), int'(e_rd_en));
      if (e_rd_en) chk("R3", "rd_addr_o", int'(rd_addr_o), e_addr);
      chk("R5", "done_o", int'(done_o), int'(e_done));
      chk("R2", "crc_o", int'(crc_o), e_crc);
      if (done_o) done_seen++;
    end
  end

  task automatic kick(int len);
    @(negedge clk);
    start_i = 1'b1;
    len_i   = LEN_W'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run(int len);
    kick(len);
    repeat (((len > DEPTH) ? DEPTH : len) + 3) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    int d0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 9; i++) mem[i] = 8'(8'h31 + i);

    repeat (3) @(negedge clk);
    chk("R9", "reset crc_o", int'(crc_o), 0);
    chk("R9", "reset done_o", int'(done_o), 0);
    chk("R9", "reset rd_en_o", int'(rd_en_o), 0);
    rst = 1'b0;
    cmp_on = 1;
    @(negedge clk);

    d0 = done_seen;
    run(9);
    chk("R1", "raw crc of 123456789", swp(crc_o), 16'h31C3);
    chk("R2", "presented crc of 123456789", int'(crc_o), 16'hC331);
    chk("R10", "done pulses per run", done_seen - d0, 1);

    run(0);
    chk("R6", "zero length crc", int'(crc_o), 0);
    run(1);
    chk("R4", "single byte", int'(crc_o), swp(ref_crc(1)));
    mem[1] = 8'hA5;
    run(2);
    chk("R4", "two bytes", int'(crc_o), swp(ref_crc(2)));
    run(DEPTH);
    chk("R8", "full depth", int'(crc_o), swp(ref_crc(DEPTH)));
    run(DEPTH + 9);
    chk("R8", "clamped length", int'(crc_o), swp(ref_crc(DEPTH)));
    run((1 << LEN_W) - 1);
    chk("R8", "max length input", int'(crc_o), swp(ref_crc(DEPTH)));

    // restart part way through
    d0 = done_seen;
    kick(20);
    repeat (4) @(negedge clk);
    run(7);
    chk("R7", "restart result", int'(crc_o), swp(ref_crc(7)));
    chk("R7", "single completion after restart", done_seen - d0, 1);

    // restart exactly on the old run's completing edge
    d0 = done_seen;
    kick(4);
    repeat (3) @(negedge clk);
    run(5);
    chk("R7", "restart on final edge", int'(crc_o), swp(ref_crc(5)));
    chk("R7", "abandoned run silent", done_seen - d0, 1);

    // zero-length restart mid-run, then back-to-back zeros
    kick(30);
    repeat (5) @(negedge clk);
    kick(0);
    kick(0);
    repeat (40) @(negedge clk);
    chk("R6", "zero restart crc", int'(crc_o), 0);

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        kick($urandom_range(1, 80));
        repeat ($urandom_range(0, 12)) @(negedge clk);
      end
      begin
        int n;
        n = $urandom_range(0, 90);
        run(n);
        chk("R1", "random run", int'(crc_o), swp(ref_crc((n > DEPTH) ? DEPTH : n)));
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    chk("R9", "idle rd_en_o", int'(rd_en_o), 0);
    summary();
    $finish;
  end
endmodule